// File: doc/BRIEF.md
# Slack-Driven Cluster Steering Predictor

This block decides where each dispatched instruction goes in a machine with one fast and one slow execution cluster, and whether it gets high or low issue priority there. It keeps a small history table keyed by the instruction address. Each entry holds one of four ordered bins: fast/high, fast/low, slow/high, slow/low. An address with no valid entry is sent fast with high priority.

The table learns slack by experiment. Every so many dispatches the block marks one dynamic instruction as a sample and states how many cycles the core should hold it back. The delay is taken in rotation from a small arithmetic set. An external criticality analyzer later returns a verdict for that instruction. Not critical means the instruction tolerated the delay. Critical means it did not. The block remembers the address and delay of the single open sample. When the verdict arrives it moves that address's entry toward the slow end or the fast end. A 2-bit confidence counter damps the movement. Only one sample is open at a time, so no dynamic instruction is ever tested twice.

Top module: `slk_steer_pred`

## Requirements
- R1: After reset every entry is invalid, so every address predicts fast/high (`pred_slow`=0, `pred_low`=0). The sample counter starts full and the delay rotation starts at its first value.
- R2: The outputs encode the bin as {`pred_slow`,`pred_low`}: 00 fast/high, 01 fast/low, 10 slow/high, 11 slow/low. Training moves a bin only one step along this order, except for the reset rule in R6.
- R3: `smp_take` rises on a dispatch cycle exactly when no sample is open and at least SMP_GAP-1 dispatches have passed without a sample since reset or since the previous sample.
- R4: Once `smp_take` has fired, no further sample is taken until a verdict arrives. A verdict that arrives while no sample is open changes nothing.
- R5: The k-th sample after reset (k from 0) carries `smp_delay` = DLY_STEP*((k mod NUM_DLY)+1).
- R6: A critical verdict on a valid, tag-matching entry handles three cases. If the sample used the smallest delay, the entry is set to fast/high with confidence 0. Otherwise, if confidence is above 0, it is decremented. Otherwise the bin steps one place toward fast/high, saturating there.
- R7: A not-critical verdict on a valid, tag-matching entry increments confidence when it is below 3. Otherwise the bin steps one place toward slow/low, saturating there.
- R8: A verdict whose entry is invalid or holds another tag takes the entry over. It writes the new tag and confidence 0, with bin fast/high for a critical verdict or fast/low for a not-critical one.
- R9: The entry index is the low IDX_W address bits. The tag XOR-folds the remaining bits: address bit IDX_W+b is folded into tag bit (b mod TAG_W). An address whose folded tag differs from the stored one predicts fast/high.
- R10: The prediction is combinational from `dsp_pc` in the same cycle. A training update becomes visible in the cycle after the verdict, and the table does not change in any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dsp_valid | input | 1 | An instruction is dispatched this cycle |
| dsp_pc | input | PC_W | Address of the dispatched instruction |
| pred_slow | output | 1 | 1 steers to the slow cluster |
| pred_low | output | 1 | 1 selects low scheduling priority |
| smp_take | output | 1 | The dispatched instruction is this cycle's slack sample |
| smp_delay | output | DLY_W | Cycles by which to delay the sampled instruction |
| vrd_valid | input | 1 | Criticality verdict for the open sample |
| vrd_crit | input | 1 | 1 means the delayed sample became critical |

## Verification
A corrupted confidence or bin field does not show up at once. It appears as a prediction that is one step off, but only when that address is dispatched again after its next verdict. The per-cycle comparison against a behavioural table therefore drives the same addresses through long climbs and descents. A wrong sample counter or delay rotation shows up at the ports within a few dispatches, as a `smp_take` on the wrong cycle or a wrong `smp_delay`. A lost or duplicated open sample shows up as a missing or extra pulse on `smp_take`.

// File: rtl/slk_pkg.sv
package slk_pkg;

  // Ordered from most urgent to most relaxed
  typedef enum logic [1:0] {
    BIN_FAST_HI = 2'b00,
    BIN_FAST_LO = 2'b01,
    BIN_SLOW_HI = 2'b10,
    BIN_SLOW_LO = 2'b11
  } slk_bin_e;

  typedef struct packed {
    logic     vld;
    logic [1:0] conf;
    slk_bin_e bin;
  } slk_meta_t;

  localparam logic [1:0] CONF_MAX = 2'd3;

endpackage

// File: rtl/slk_sampler.sv
module slk_sampler #(
  parameter int PC_W     = 16,
  parameter int SMP_GAP  = 4,
  parameter int NUM_DLY  = 4,
  parameter int DLY_STEP = 4,
  localparam int DLY_W   = $clog2(DLY_STEP * NUM_DLY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dsp_valid,
  input  logic [PC_W-1:0]  dsp_pc,
  input  logic             vrd_valid,
  output logic             smp_take,
  output logic [DLY_W-1:0] smp_delay,
  output logic             trn_en,
  output logic             pend_q,
  output logic [PC_W-1:0]  pend_pc_q,
  output logic             pend_min_q
);

  localparam int CNT_W = (SMP_GAP > 2) ? $clog2(SMP_GAP) : 1;
  localparam int K_W   = (NUM_DLY > 2) ? $clog2(NUM_DLY) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SMP_GAP - 1);
  localparam logic [K_W-1:0]   K_LAST   = K_W'(NUM_DLY - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [K_W-1:0]   k_q, k_d;
  logic             pend_d, pmin_d;
  logic [PC_W-1:0]  ppc_d;

  assign smp_take  = dsp_valid && (cnt_q == '0) && !pend_q;
  assign trn_en    = vrd_valid && pend_q;
  assign smp_delay = DLY_W'((int'(k_q) + 1) * DLY_STEP);

  always_comb begin
    cnt_d  = cnt_q;
    k_d    = k_q;
    pend_d = pend_q;
    ppc_d  = pend_pc_q;
    pmin_d = pend_min_q;
    if (trn_en) pend_d = 1'b0;
    if (smp_take) begin
      cnt_d  = CNT_LOAD;
      k_d    = (k_q == K_LAST) ? '0 : k_q + 1'b1;
      pend_d = 1'b1;
      ppc_d  = dsp_pc;
      pmin_d = (k_q == '0);
    end else if (dsp_valid && cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= CNT_LOAD;
      k_q        <= '0;
      pend_q     <= 1'b0;
      pend_min_q <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      k_q        <= k_d;
      pend_q     <= pend_d;
      pend_min_q <= pmin_d;
    end
  end

  // Payload register: captured only with a new sample
  always_ff @(posedge clk) begin
    if (smp_take) pend_pc_q <= ppc_d;
  end

endmodule

// File: rtl/slk_table.sv
module slk_table
  import slk_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int IDX_W = 3,
  parameter int TAG_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] rd_pc,
  output slk_bin_e        rd_bin,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_pc,
  input  logic            wr_crit,
  input  logic            wr_min
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int HI_W    = PC_W - IDX_W;

  function automatic logic [TAG_W-1:0] fold_tag(input logic [PC_W-1:0] pc);
    logic [TAG_W-1:0] t;
    t = '0;
    for (int b = 0; b < HI_W; b++) t[b % TAG_W] = t[b % TAG_W] ^ pc[IDX_W + b];
    return t;
  endfunction

  slk_meta_t        meta_q [ENTRIES];
  logic [TAG_W-1:0] tag_q  [ENTRIES];

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [TAG_W-1:0] rd_tag, wr_tag;
  logic             rd_hit, wr_hit;
  slk_meta_t        cur, upd;

  assign rd_idx = rd_pc[IDX_W-1:0];
  assign rd_tag = fold_tag(rd_pc);
  assign rd_hit = meta_q[rd_idx].vld && (tag_q[rd_idx] == rd_tag);
  assign rd_bin = rd_hit ? meta_q[rd_idx].bin : BIN_FAST_HI;

  assign wr_idx = wr_pc[IDX_W-1:0];
  assign wr_tag = fold_tag(wr_pc);
  assign cur    = meta_q[wr_idx];
  assign wr_hit = cur.vld && (tag_q[wr_idx] == wr_tag);

  always_comb begin
    upd = cur;
    if (!wr_hit) begin
      upd.vld  = 1'b1;
      upd.conf = '0;
      upd.bin  = wr_crit ? BIN_FAST_HI : BIN_FAST_LO;
    end else if (wr_crit) begin
      if (wr_min) begin
        upd.conf = '0;
        upd.bin  = BIN_FAST_HI;
      end else if (cur.conf != '0) begin
        upd.conf = cur.conf - 1'b1;
      end else if (cur.bin != BIN_FAST_HI) begin
        upd.bin = slk_bin_e'(cur.bin - 2'd1);
      end
    end else begin
      if (cur.conf != CONF_MAX) begin
        upd.conf = cur.conf + 1'b1;
      end else if (cur.bin != BIN_SLOW_LO) begin
        upd.bin = slk_bin_e'(cur.bin + 2'd1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) meta_q[i] <= '0;
    end else if (wr_en) begin
      meta_q[wr_idx] <= upd;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

endmodule

// File: rtl/slk_steer_pred.sv
module slk_steer_pred
  import slk_pkg::*;
#(
  parameter int PC_W     = 16,
  parameter int IDX_W    = 3,
  parameter int TAG_W    = 4,
  parameter int SMP_GAP  = 4,
  parameter int NUM_DLY  = 4,
  parameter int DLY_STEP = 4,
  localparam int DLY_W   = $clog2(DLY_STEP * NUM_DLY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dsp_valid,
  input  logic [PC_W-1:0]  dsp_pc,
  output logic             pred_slow,
  output logic             pred_low,
  output logic             smp_take,
  output logic [DLY_W-1:0] smp_delay,
  input  logic             vrd_valid,
  input  logic             vrd_crit
);

  logic [1:0]      rst_pipe_q;
  logic            rst_core_n;
  logic            trn_en, pend_q, pend_min_q;
  logic [PC_W-1:0] pend_pc_q;
  slk_bin_e        bin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  slk_sampler #(
    .PC_W(PC_W), .SMP_GAP(SMP_GAP), .NUM_DLY(NUM_DLY), .DLY_STEP(DLY_STEP)
  ) u_smp (
    .clk(clk), .rst_n(rst_core_n), .dsp_valid(dsp_valid), .dsp_pc(dsp_pc),
    .vrd_valid(vrd_valid), .smp_take(smp_take), .smp_delay(smp_delay),
    .trn_en(trn_en), .pend_q(pend_q), .pend_pc_q(pend_pc_q), .pend_min_q(pend_min_q)
  );

  slk_table #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tbl (
    .clk(clk), .rst_n(rst_core_n), .rd_pc(dsp_pc), .rd_bin(bin),
    .wr_en(trn_en), .wr_pc(pend_pc_q), .wr_crit(vrd_crit), .wr_min(pend_min_q)
  );

  assign pred_slow = bin[1];
  assign pred_low  = bin[0];

endmodule

// File: rtl/slk_steer_pred_chk.sv
module slk_steer_pred_chk #(
  parameter int PC_W     = 16,
  parameter int SMP_GAP  = 4,
  parameter int NUM_DLY  = 4,
  parameter int DLY_STEP = 4,
  localparam int DLY_W   = $clog2(DLY_STEP * NUM_DLY + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dsp_valid,
  input logic [PC_W-1:0]  dsp_pc,
  input logic             pred_slow,
  input logic             pred_low,
  input logic             smp_take,
  input logic [DLY_W-1:0] smp_delay,
  input logic             vrd_valid,
  input logic             vrd_crit,
  input logic             pend,
  input logic [PC_W-1:0]  pend_pc
);

  localparam int SW = $clog2(SMP_GAP) + 1;
  logic [SW-1:0] since_q;
  logic          on_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   since_q <= '0;
    else if (smp_take)                            since_q <= '0;
    else if (dsp_valid && since_q < SW'(SMP_GAP - 1)) since_q <= since_q + 1'b1;
  end

  assign on_pend = vrd_valid && pend && dsp_valid && (dsp_pc == pend_pc);

  AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    smp_take |-> since_q >= SW'(SMP_GAP - 1)); // R3
  AST_GAP_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_valid && !pend && since_q >= SW'(SMP_GAP - 1)) |-> smp_take); // R3
  AST_ONE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    smp_take |=> !smp_take); // R4
  AST_DLY_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    smp_take |-> (smp_delay != '0 && (int'(smp_delay) % DLY_STEP) == 0
                  && int'(smp_delay) <= DLY_STEP * NUM_DLY)); // R5
  AST_CRIT_NO_SLOWER: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(on_pend && vrd_crit) && dsp_valid && dsp_pc == $past(dsp_pc))
      |-> {pred_slow, pred_low} <= $past({pred_slow, pred_low})); // R6
  AST_CALM_NO_FASTER: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(on_pend && !vrd_crit) && dsp_valid && dsp_pc == $past(dsp_pc))
      |-> {pred_slow, pred_low} >= $past({pred_slow, pred_low})); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(vrd_valid) && dsp_valid && $past(dsp_valid) && dsp_pc == $past(dsp_pc))
      |-> ($stable(pred_slow) && $stable(pred_low))); // R10

endmodule

bind slk_steer_pred slk_steer_pred_chk #(
  .PC_W(PC_W), .SMP_GAP(SMP_GAP), .NUM_DLY(NUM_DLY), .DLY_STEP(DLY_STEP)
) u_chk (
  .clk(clk), .rst_n(rst_core_n), .dsp_valid(dsp_valid), .dsp_pc(dsp_pc),
  .pred_slow(pred_slow), .pred_low(pred_low), .smp_take(smp_take),
  .smp_delay(smp_delay), .vrd_valid(vrd_valid), .vrd_crit(vrd_crit),
  .pend(pend_q), .pend_pc(pend_pc_q)
);

// File: tb/sim_slk_steer_pred.sv
module sim_slk_steer_pred;

  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 16, IDX_W = 3, TAG_W = 4;
  localparam int SMP_GAP = 4, NUM_DLY = 4, DLY_STEP = 4;
  localparam int DLY_W = $clog2(DLY_STEP * NUM_DLY + 1);
  localparam int ENT = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dsp_valid = 1'b0;
  logic [PC_W-1:0] dsp_pc = '0;
  logic vrd_valid = 1'b0, vrd_crit = 1'b0;
  logic pred_slow, pred_low, smp_take;
  logic [DLY_W-1:0] smp_delay;

  always #(CLK_PERIOD / 2) clk = ~clk;

  slk_steer_pred u0 (
    .clk(clk), .rst_n(rst_n), .dsp_valid(dsp_valid), .dsp_pc(dsp_pc),
    .pred_slow(pred_slow), .pred_low(pred_low), .smp_take(smp_take),
    .smp_delay(smp_delay), .vrd_valid(vrd_valid), .vrd_crit(vrd_crit)
  );

  // Behavioural reference
  bit m_vld [ENT];
  int m_tag [ENT];
  int m_conf[ENT];
  int m_bin [ENT];
  int m_cnt = SMP_GAP - 1, m_k = 0, m_wait = 0, m_pk = 0;
  bit m_pend = 0;
  int m_ppc = 0;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] lfsr = 16'hACE1;

  localparam int PC_A = 16'h0125, PC_B = 16'h012D, PC_C = 16'h0F42, PC_D = 16'h3A07;

  function automatic int ref_tag(int pc);
    int t = 0;
    for (int b = 0; b < PC_W - IDX_W; b++)
      if ((pc >> (IDX_W + b)) & 1) t = t ^ (1 << (b % TAG_W));
    return t;
  endfunction

  function automatic int ref_bin(int pc);
    int i = pc % ENT;
    if (m_vld[i] && m_tag[i] == ref_tag(pc)) return m_bin[i];
    return 0;
  endfunction

  task automatic train(int pc, bit crit, bit first);
    int i = pc % ENT;
    if (!(m_vld[i] && m_tag[i] == ref_tag(pc))) begin      // R8
      m_vld[i] = 1; m_tag[i] = ref_tag(pc); m_conf[i] = 0; m_bin[i] = crit ? 0 : 1;
    end else if (crit) begin                                // R6
      if (first) begin m_conf[i] = 0; m_bin[i] = 0; end
      else if (m_conf[i] > 0) m_conf[i]--;
      else if (m_bin[i] > 0) m_bin[i]--;
    end else begin                                          // R7
      if (m_conf[i] < 3) m_conf[i]++;
      else if (m_bin[i] < 3) m_bin[i]++;
    end
  endtask

  function automatic int pick_pc(int pm, int cyc);
    case (pm)
      1: return cyc[0] ? PC_B : PC_A;                       // R9 alias pair
      2: case (lfsr[1:0]) 0: return PC_A; 1: return PC_B; 2: return PC_C; default: return PC_D; endcase
      default: return PC_A;
    endcase
  endfunction

  // pm: 0 fixed A, 1 alias A/B, 2 random, 3 idle, 4 random with gaps
  // vm: 0 not critical, 1 critical, 2 random, 3 random plus stray verdicts
  task automatic run(input string tag, input int n, input int pm, input int vm);
    for (int c = 0; c < n; c++) begin
      bit tk;
      int eb, ed;
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      dsp_valid = (pm == 3) ? 1'b0 : (pm == 4) ? lfsr[3] : 1'b1;
      dsp_pc    = PC_W'(pick_pc(pm == 4 ? 2 : pm, c));
      vrd_valid = 1'b0;
      vrd_crit  = (vm == 1) ? 1'b1 : (vm == 0) ? 1'b0 : lfsr[5];
      if (m_pend && m_wait >= 2) vrd_valid = 1'b1;
      else if (!m_pend && vm == 3) vrd_valid = lfsr[7];    // R4 stray verdict
      #1;
      eb = ref_bin(int'(dsp_pc));
      tk = dsp_valid && m_cnt == 0 && !m_pend;
      ed = DLY_STEP * (m_k + 1);
      n_cmp++;
      // R10: combinational prediction from current pc, previous training visible
      if ({pred_slow, pred_low} !== 2'(eb)) begin
        n_bad++;
        $display("FAIL %s bin pc=%h got=%0d exp=%0d", tag, dsp_pc, {pred_slow, pred_low}, eb);
      end
      if (smp_take !== tk) begin
        n_bad++;
        $display("FAIL R3/R4 (%s) smp_take got=%0b exp=%0b", tag, smp_take, tk);
      end
      if (tk && int'(smp_delay) != ed) begin
        n_bad++;
        $display("FAIL R5 (%s) smp_delay got=%0d exp=%0d", tag, smp_delay, ed);
      end
      // reference update for the coming edge
      if (vrd_valid && m_pend) begin
        train(m_ppc, vrd_crit, m_pk == 0);
        m_pend = 0;
      end else if (m_pend) m_wait++;
      if (tk) begin
        m_pend = 1; m_wait = 0; m_ppc = int'(dsp_pc); m_pk = m_k;
        m_k = (m_k + 1) % NUM_DLY; m_cnt = SMP_GAP - 1;
      end else if (dsp_valid && m_cnt > 0) m_cnt--;
    end
  endtask

  initial begin
    for (int i = 0; i < ENT; i++) begin m_vld[i] = 0; m_tag[i] = 0; m_conf[i] = 0; m_bin[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    run("R1", 4, 3, 0);     // reset state, synchronizer still releasing
    run("R1", 6, 2, 0);
    run("R3", 12, 4, 0);
    run("R7", 80, 0, 0);    // climb to slow/low
    run("R6", 80, 0, 1);    // descend, incl. smallest-delay reset
    run("R8", 40, 1, 1);
    run("R9", 40, 1, 2);
    run("R4", 60, 2, 3);
    run("R5", 60, 0, 2);
    run("R2", 300, 2, 2);
    run("R10", 200, 4, 3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule